// File: doc/BRIEF.md
# Cyclic Shared Output Buffer

This block is one output plane of a cell switch. In the transmission phase of a switch cycle it receives up to `LANES` winning cells on parallel slots. Each cell it accepts is steered through a rotating lane selector into one of `LANES` small FIFOs, so that accepted cells fill the lanes in round-robin order. In the preparation phase it removes one head-of-line cell, visiting the lanes in the same round-robin order. The lanes together behave as one shared first-in first-out queue of `CAP` cells that has `LANES` write ports.

Admission is governed by two values: a total capacity `CAP` and a threshold `THRESH`. Slots are examined in index order against a running occupancy. A low-priority cell is dropped when that occupancy has reached the threshold. Any cell is dropped when the occupancy has reached capacity. A dropped cell takes no lane slot, and the write lane moves on only by the number of cells accepted.

Top module: `cso_out_plane`

## Requirements
- R1: After reset the buffer is empty and `out_vld` is low.
- R2: Accepted cells leave in arrival order. Within one write phase, lower slot indices count as earlier, so the plane acts as a single FIFO.
- R3: A read strobe on a non-empty buffer pops exactly one cell. `out_vld` is high in the following cycle only, and `out_cell` carries the oldest stored cell.
- R4: A read strobe on an empty buffer gives `out_vld` low in the following cycle.
- R5: A valid low-priority slot (`in_low` bit 1) is dropped when the running occupancy is at or above `THRESH`.
- R6: Any valid slot is dropped when the running occupancy equals `CAP`.
- R7: The running occupancy grows with each cell accepted earlier in the same write phase. A later low-priority slot can therefore be dropped after earlier slots of that phase were accepted.
- R8: A dropped cell consumes no storage. The cells accepted after a drop still leave contiguously and in order.
- R9: Slots whose `in_vld` bit is 0 are ignored, and all slots are ignored in cycles where `wr_phase` is low.
- R10: Occupancy never exceeds `CAP`. Draining a buffer that has been overfilled returns exactly `CAP` cells.
- R11: When `wr_phase` and `rd_phase` are both high in one cycle, admission is judged on the occupancy before that cycle's pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_phase | input | 1 | Write strobe: the slots are offered this cycle |
| in_vld | input | LANES | Per-slot cell present |
| in_low | input | LANES | Per-slot low-priority flag (1 = low) |
| in_cell | input | LANES*CELL_W | Slot cells; slot i at bits [i*CELL_W +: CELL_W] |
| rd_phase | input | 1 | Read strobe: pop one head-of-line cell |
| out_vld | output | 1 | Output cell valid, one cycle after a successful pop |
| out_cell | output | CELL_W | Popped cell |

## Verification
The assertions assume that `wr_phase` and `rd_phase` are single-cycle strobes. They also assume that a slot's priority flag only has meaning while its valid bit is set. Some properties are written for the case where a write phase has no pop in the same cycle, and the capacity and threshold properties depend on that restriction. The stimulus mostly keeps the two strobes in separate cycles. It overlaps them on purpose in a randomized stretch and in one capacity case, and the bench model covers those overlapped cycles. Every cell carries a unique sequence value, so any loss, duplication or reordering shows up at the output.

// File: rtl/cso_pkg.sv
package cso_pkg;

    // Reduce a value below 2*n into the range [0, n).
    function automatic int unsigned wrap_idx(input int unsigned v, input int unsigned n);
        return (v >= n) ? v - n : v;
    endfunction

endpackage

// File: rtl/cso_admit.sv
module cso_admit #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CAP    = 24,
    parameter int unsigned THRESH = 18,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [LANES-1:0]            slot_vld,
    input  logic [LANES-1:0]            slot_low,
    input  logic [CNT_W-1:0]            occ,
    input  logic [IDX_W-1:0]            wsel,
    output logic [LANES-1:0]            lane_we,
    output logic [LANES-1:0][IDX_W-1:0] lane_src,
    output logic [CNT_W-1:0]            acc_n,
    output logic [IDX_W-1:0]            wsel_next
);

    logic [IDX_W-1:0] lane_sel;

    // Slots in index order against a running occupancy; each accepted
    // cell lands in the next lane after the rotating write selector.
    always_comb begin
        int unsigned run;
        int unsigned took;
        run      = 32'(occ);
        took     = 0;
        lane_we  = '0;
        lane_src = '0;
        lane_sel = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (slot_vld[i] && (run < CAP) && !(slot_low[i] && (run >= THRESH))) begin
                lane_sel           = IDX_W'(cso_pkg::wrap_idx(32'(wsel) + took, LANES));
                lane_we[lane_sel]  = 1'b1;
                lane_src[lane_sel] = IDX_W'(i);
                run                = run + 1;
                took               = took + 1;
            end
        end
        acc_n     = CNT_W'(took);
        wsel_next = IDX_W'(cso_pkg::wrap_idx(32'(wsel) + took, LANES));
    end

endmodule

// File: rtl/cso_lane.sv
module cso_lane #(
    parameter int unsigned CELL_W = 16,
    parameter int unsigned DEPTH  = 6,
    localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [CELL_W-1:0] pdata,
    input  logic              pop,
    output logic [CELL_W-1:0] head
);

    typedef struct packed {
        logic [DEPTH-1:0][CELL_W-1:0] mem;
        logic [PW-1:0]                hd;
        logic [PW-1:0]                tl;
    } lane_st_t;

    lane_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.tl] = pdata;
            st_d.tl           = bump(st_q.tl);
        end
        if (pop) begin
            st_d.hd = bump(st_q.hd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign head = st_q.mem[st_q.hd];

endmodule

// File: rtl/cso_out_plane.sv
module cso_out_plane #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CELL_W = 16,
    parameter int unsigned CAP    = 24,
    parameter int unsigned THRESH = 18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_phase,
    input  logic [LANES-1:0]          in_vld,
    input  logic [LANES-1:0]          in_low,
    input  logic [LANES*CELL_W-1:0]   in_cell,
    input  logic                      rd_phase,
    output logic                      out_vld,
    output logic [CELL_W-1:0]         out_cell
);

    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned CNT_W = $clog2(CAP + 1);
    localparam int unsigned DEPTH = (CAP + LANES - 1) / LANES;

    typedef struct packed {
        logic [CNT_W-1:0]  occ;
        logic [IDX_W-1:0]  wsel;
        logic [IDX_W-1:0]  rsel;
        logic              ovld;
        logic [CELL_W-1:0] ocell;
    } plane_st_t;

    plane_st_t st_d, st_q;

    logic [LANES-1:0]            slot_vld;
    logic [LANES-1:0]            lane_we;
    logic [LANES-1:0][IDX_W-1:0] lane_src;
    logic [CNT_W-1:0]            acc_n;
    logic [IDX_W-1:0]            wsel_next;
    logic [CELL_W-1:0]           lane_data [LANES];
    logic [CELL_W-1:0]           lane_head [LANES];
    logic                        pop_en;
    logic [CNT_W-1:0]            occ;
    logic [IDX_W-1:0]            rsel;

    assign occ      = st_q.occ;
    assign rsel     = st_q.rsel;
    assign slot_vld = wr_phase ? in_vld : '0;
    assign pop_en   = rd_phase && (st_q.occ != '0);

    cso_admit #(
        .LANES (LANES),
        .CAP   (CAP),
        .THRESH(THRESH),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_admit (
        .slot_vld (slot_vld),
        .slot_low (in_low),
        .occ      (st_q.occ),
        .wsel     (st_q.wsel),
        .lane_we  (lane_we),
        .lane_src (lane_src),
        .acc_n    (acc_n),
        .wsel_next(wsel_next)
    );

    // Rotating steering: each lane picks the slot the admitter assigned to it.
    always_comb begin
        for (int g = 0; g < int'(LANES); g++) begin
            lane_data[g] = '0;
            for (int s = 0; s < int'(LANES); s++) begin
                if (lane_src[g] == IDX_W'(s)) lane_data[g] = in_cell[s*CELL_W +: CELL_W];
            end
        end
    end

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        cso_lane #(
            .CELL_W(CELL_W),
            .DEPTH (DEPTH)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .push (lane_we[g]),
            .pdata(lane_data[g]),
            .pop  (pop_en && (st_q.rsel == IDX_W'(g))),
            .head (lane_head[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.occ  = st_q.occ + acc_n - CNT_W'(pop_en);
        st_d.wsel = wsel_next;
        st_d.ovld = pop_en;
        if (pop_en) begin
            st_d.ocell = lane_head[st_q.rsel];
            st_d.rsel  = IDX_W'(cso_pkg::wrap_idx(32'(st_q.rsel) + 1, LANES));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld  = st_q.ovld;
    assign out_cell = st_q.ocell;

endmodule

// File: rtl/cso_out_plane_chk.sv
module cso_out_plane_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CAP    = 24,
    parameter int unsigned THRESH = 18,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned IDX_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_phase,
    input logic             rd_phase,
    input logic [LANES-1:0] in_vld,
    input logic [LANES-1:0] in_low,
    input logic [CNT_W-1:0] occ,
    input logic [IDX_W-1:0] rsel,
    input logic             out_vld
);

    int               hi_n;
    logic [IDX_W-1:0] rsel_nx;

    assign hi_n    = $countones(in_vld & ~in_low);
    assign rsel_nx = (rsel == IDX_W'(LANES - 1)) ? '0 : rsel + 1'b1;

    a_r10_occ_cap: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= int'(CAP));

    a_r3_read_pops: assert property (@(posedge clk) disable iff (rst)
        (rd_phase && occ != '0) |=> out_vld);

    a_r3_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(rd_phase));

    a_r3_read_lane_step: assert property (@(posedge clk) disable iff (rst)
        (rd_phase && occ != '0) |=> rsel == $past(rsel_nx));

    a_r4_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd_phase && occ == '0) |=> !out_vld);

    a_r5_low_blocked: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && !rd_phase && int'(occ) >= int'(THRESH))
            |=> int'(occ) <= int'($past(occ)) + $past(hi_n));

    a_r6_full_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_phase && !rd_phase && int'(occ) == int'(CAP)) |=> int'(occ) == int'(CAP));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_phase && !rd_phase) |=> $stable(occ));

endmodule

bind cso_out_plane cso_out_plane_chk #(
    .LANES (LANES),
    .CAP   (CAP),
    .THRESH(THRESH),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_phase(wr_phase),
    .rd_phase(rd_phase),
    .in_vld  (in_vld),
    .in_low  (in_low),
    .occ     (occ),
    .rsel    (rsel),
    .out_vld (out_vld)
);

// File: tb/cso_out_plane_tb.sv
module cso_out_plane_tb;

    localparam int CLK_PERIOD = 10;
    localparam int L  = 4;
    localparam int W  = 16;
    localparam int SO = 24;
    localparam int TO = 18;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_phase = 1'b0;
    logic [L-1:0]   in_vld = '0;
    logic [L-1:0]   in_low = '0;
    logic [L*W-1:0] in_cell = '0;
    logic           rd_phase = 1'b0;
    logic           out_vld;
    logic [W-1:0]   out_cell;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] q [$];
    logic [W-1:0] seq = 16'h0100;
    logic         exp_vld = 1'b0;
    logic [W-1:0] exp_cell = '0;
    string        prev_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cso_out_plane #(.LANES(L), .CELL_W(W), .CAP(SO), .THRESH(TO)) u_dut (
        .clk(clk), .rst(rst), .wr_phase(wr_phase), .in_vld(in_vld), .in_low(in_low),
        .in_cell(in_cell), .rd_phase(rd_phase), .out_vld(out_vld), .out_cell(out_cell)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One clock: check outputs of the previous edge, then drive and predict.
    task automatic step(input logic wr, input logic [L-1:0] v, input logic [L-1:0] lo,
                        input logic rd, input string req);
        int run;
        @(negedge clk);
        checks++;
        if (out_vld !== exp_vld) begin
            failures++;
            $display("FAIL %s out_vld actual=%0b expected=%0b", prev_req, out_vld, exp_vld);
        end
        if (exp_vld) begin
            checks++;
            if (out_cell !== exp_cell) begin
                failures++;
                $display("FAIL %s out_cell actual=%h expected=%h", prev_req, out_cell, exp_cell);
            end
        end
        wr_phase = wr; in_vld = v; in_low = lo; rd_phase = rd;
        for (int i = 0; i < L; i++) begin
            in_cell[i*W +: W] = seq;
            seq = seq + 1'b1;
        end
        run = q.size();
        exp_vld = rd && (run > 0);
        if (exp_vld) exp_cell = q.pop_front();
        if (wr) begin
            for (int i = 0; i < L; i++) begin
                if (v[i] && run < SO && !(lo[i] && run >= TO)) begin
                    q.push_back(in_cell[i*W +: W]);
                    run++;
                end
            end
        end
        prev_req = req;
    endtask

    task automatic drain(input int n, input string req);
        for (int k = 0; k < n; k++) step(1'b0, '0, '0, 1'b1, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then R4: read on empty
        step(1'b0, '0, '0, 1'b1, "R4");
        step(1'b0, '0, '0, 1'b0, "R4");
        // R2 / R3: several write patterns, then drain in order
        step(1'b1, 4'b1111, 4'b0000, 1'b0, "R2");
        step(1'b1, 4'b0101, 4'b0100, 1'b0, "R2");
        step(1'b1, 4'b1000, 4'b1000, 1'b0, "R2");
        step(1'b1, 4'b0110, 4'b0000, 1'b0, "R3");
        drain(10, "R3");
        // R9: valid slots without a write strobe, and strobe with no valid slots
        step(1'b0, 4'b1111, 4'b0000, 1'b0, "R9");
        step(1'b1, 4'b0000, 4'b1111, 1'b0, "R9");
        step(1'b1, 4'b0010, 4'b0000, 1'b0, "R9");
        drain(3, "R9");
        // R5 / R7 / R8: fill to TO-1, then low,low,high,low in one phase
        for (int k = 0; k < 4; k++) step(1'b1, 4'b1111, 4'b0000, 1'b0, "R5");
        step(1'b1, 4'b0001, 4'b0000, 1'b0, "R5");
        step(1'b1, 4'b1111, 4'b1011, 1'b0, "R7");
        step(1'b1, 4'b0011, 4'b0011, 1'b0, "R5");
        drain(21, "R8");
        // R6 / R10 / R11: overfill, coincident strobes, drain exactly SO
        for (int k = 0; k < 6; k++) step(1'b1, 4'b1111, 4'b0000, 1'b0, "R6");
        step(1'b1, 4'b1111, 4'b0000, 1'b0, "R6");
        step(1'b1, 4'b1111, 4'b0000, 1'b1, "R11");
        step(1'b1, 4'b1111, 4'b1110, 1'b0, "R11");
        drain(26, "R10");
        // R2: random traffic including coincident strobes
        for (int k = 0; k < 300; k++)
            step(1'($urandom), 4'($urandom), 4'($urandom), 1'($urandom_range(0, 2) != 0), "R2");
        drain(30, "R2");
        step(1'b0, '0, '0, 1'b0, "R2");
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

endmodule